// File: doc/BRIEF.md
# Receive Address Filter

This block decides whether an incoming Ethernet frame is kept or dropped. It looks only at the frame's 48-bit destination address and its length, and it compares them with four configuration words: a filter-flags word, the station address, one programmable multicast address and a multicast mask. It is evaluated once for each frame, when the upstream parser has extracted the destination field and pulses a valid strobe.

The rules are tried in a fixed priority, and the first rule that applies decides the frame:
- A frame too short to hold a destination field is dropped.
- The broadcast address is always kept.
- A clear "check address" flag keeps everything.
- A masked compare against the multicast address keeps matching groups, unless that address is all ones.
- Exact equality with the station address keeps unicast frames.

The decision is registered. It appears one cycle after the strobe, together with a single-cycle done pulse and a class code that names the rule which decided.

Top module: `rx_addr_filter`

## Requirements
- R1: A destination of all ones (FF:FF:FF:FF:FF:FF) is accepted with class 1, whatever the flags, multicast and station settings.
- R2: With flag bit 5 of `flt_flags` clear, a non-broadcast frame is accepted with class 2. The other flag bits have no effect on the decision.
- R3: When `mcast_addr` is all ones, the multicast rule never decides, and the frame falls through to the unicast rule.
- R4: With flag bit 5 set, a frame whose destination ANDed bit by bit with `mcast_mask` equals `mcast_addr` is accepted with class 3.
- R5: A frame not taken by an earlier rule whose destination equals `station_addr` exactly is accepted with class 4. A difference in any single bit does not match.
- R6: A frame of valid length that no rule accepts is rejected with class 0.
- R7: The rules are checked in this priority: broadcast, then the flag test, then multicast, then unicast. The class reports the first rule that applies.
- R8: A frame with `frm_len` below 6 bytes is rejected with class 5, even when its destination is broadcast. A length of exactly 6 is evaluated normally.
- R9: `dec_done` is high for exactly the cycle after each cycle with `frm_valid` high, and low otherwise. Back-to-back strobes give back-to-back decisions.
- R10: After reset `dec_done`, `dec_accept` and `dec_class` are 0. `dec_accept` and `dec_class` are 0 whenever `dec_done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: destination and length are valid |
| frm_len | input | 16 | Frame length in bytes |
| dst_addr | input | 48 | Destination address, first octet in bits 47:40 |
| flt_flags | input | 32 | Filter flags; bit 5 enables address checking |
| station_addr | input | 48 | Station (unicast) address |
| mcast_addr | input | 48 | Multicast compare address; all ones disables the rule |
| mcast_mask | input | 48 | Mask ANDed with the destination before the multicast compare |
| dec_done | output | 1 | One-cycle pulse: a decision is presented |
| dec_accept | output | 1 | 1 = keep the frame, 0 = drop it |
| dec_class | output | 3 | Deciding rule: 0 none, 1 broadcast, 2 open, 3 multicast, 4 unicast, 5 short |

## Verification
The block holds no state between frames, so a fault in it shows at the ports as a wrong accept bit or class code one cycle after the strobe that caused it. A mistake in the priority appears only when two rules apply at once. The stimulus therefore includes frames that are both short and broadcast, broadcast with the flag clear, and multicast matches that equal the station address. A register that does not clear shows as a done pulse, or a non-zero class, in a cycle with no preceding strobe.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int OCTET_W = 8;

  typedef enum logic [2:0] {
    RC_NONE  = 3'd0,
    RC_BCAST = 3'd1,
    RC_OPEN  = 3'd2,
    RC_MCAST = 3'd3,
    RC_UCAST = 3'd4,
    RC_SHORT = 3'd5
  } rxf_class_e;
endpackage

// File: rtl/rxf_octet_cmp.sv
module rxf_octet_cmp #(
  parameter int NOCT = 6
) (
  input  logic [NOCT*8-1:0] dst,
  input  logic [NOCT*8-1:0] station,
  input  logic [NOCT*8-1:0] mc_addr,
  input  logic [NOCT*8-1:0] mc_mask,
  output logic              is_bcast,
  output logic              mc_hit,
  output logic              mc_off,
  output logic              uc_hit
);
  localparam int OW = rxf_pkg::OCTET_W;

  logic [NOCT-1:0] oct_bc, oct_mc, oct_mcall, oct_uc;

  // One comparator slice per address octet.
  for (genvar i = 0; i < NOCT; i++) begin : g_oct
    logic [OW-1:0] d_o;
    assign d_o          = dst[i*OW +: OW];
    assign oct_bc[i]    = &d_o;
    assign oct_mcall[i] = &mc_addr[i*OW +: OW];
    assign oct_mc[i]    = ((d_o & mc_mask[i*OW +: OW]) == mc_addr[i*OW +: OW]);
    assign oct_uc[i]    = (d_o == station[i*OW +: OW]);
  end

  assign is_bcast = &oct_bc;
  assign mc_off   = &oct_mcall;
  assign mc_hit   = &oct_mc;
  assign uc_hit   = &oct_uc;
endmodule

// File: rtl/rxf_prio.sv
module rxf_prio (
  input  logic               too_short,
  input  logic               is_bcast,
  input  logic               chk_en,
  input  logic               mc_off,
  input  logic               mc_hit,
  input  logic               uc_hit,
  output logic               accept,
  output rxf_pkg::rxf_class_e cls
);
  import rxf_pkg::*;

  always_comb begin
    accept = 1'b0;
    cls    = RC_NONE;
    if (too_short) begin
      cls = RC_SHORT;
    end else if (is_bcast) begin
      accept = 1'b1;
      cls    = RC_BCAST;
    end else if (!chk_en) begin
      accept = 1'b1;
      cls    = RC_OPEN;
    end else if (!mc_off && mc_hit) begin
      accept = 1'b1;
      cls    = RC_MCAST;
    end else if (uc_hit) begin
      accept = 1'b1;
      cls    = RC_UCAST;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ADDR_W   = 48,
  parameter int FLAG_W   = 32,
  parameter int CHK_BIT  = 5,
  parameter int LEN_W    = 16,
  parameter int MIN_LEN  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [FLAG_W-1:0] flt_flags,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic [ADDR_W-1:0] mcast_addr,
  input  logic [ADDR_W-1:0] mcast_mask,
  output logic              dec_done,
  output logic              dec_accept,
  output logic [2:0]        dec_class
);
  import rxf_pkg::*;

  localparam int NOCT = ADDR_W / OCTET_W;

  logic       is_bcast, mc_hit, mc_off, uc_hit, too_short;
  logic       acc_c;
  rxf_class_e cls_c;
  logic       flags_unused;

  assign too_short    = (frm_len < LEN_W'(MIN_LEN));
  assign flags_unused = ^(flt_flags & ~(FLAG_W'(1) << CHK_BIT));

  rxf_octet_cmp #(.NOCT(NOCT)) u_cmp (
    .dst      (dst_addr),
    .station  (station_addr),
    .mc_addr  (mcast_addr),
    .mc_mask  (mcast_mask),
    .is_bcast (is_bcast),
    .mc_hit   (mc_hit),
    .mc_off   (mc_off),
    .uc_hit   (uc_hit)
  );

  rxf_prio u_prio (
    .too_short (too_short),
    .is_bcast  (is_bcast),
    .chk_en    (flt_flags[CHK_BIT]),
    .mc_off    (mc_off),
    .mc_hit    (mc_hit),
    .uc_hit    (uc_hit),
    .accept    (acc_c),
    .cls       (cls_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_done   <= 1'b0;
      dec_accept <= 1'b0;
      dec_class  <= RC_NONE;
    end else begin
      dec_done   <= frm_valid;
      dec_accept <= frm_valid & acc_c;
      dec_class  <= frm_valid ? cls_c : RC_NONE;
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int ADDR_W  = 48,
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_valid,
  input logic [LEN_W-1:0]  frm_len,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [ADDR_W-1:0] station_addr,
  input logic              chk_flag,
  input logic              dec_done,
  input logic              dec_accept,
  input logic [2:0]        dec_class
);
  logic len_ok, bc;
  assign len_ok = (frm_len >= LEN_W'(MIN_LEN));
  assign bc     = &dst_addr;

  p_done_follows_r9: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> dec_done);
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |=> !dec_done);
  p_short_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !len_ok) |=> (!dec_accept && dec_class == 3'd5));
  p_bcast_keep_r1: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && len_ok && bc) |=> (dec_accept && dec_class == 3'd1));
  p_open_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && len_ok && !bc && !chk_flag) |=> (dec_accept && dec_class == 3'd2));
  p_ucast_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && len_ok && chk_flag && dst_addr == station_addr) |=> dec_accept);
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !dec_done |-> (!dec_accept && dec_class == 3'd0));
endmodule

bind rx_addr_filter rxf_checker #(
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W),
  .MIN_LEN(MIN_LEN)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frm_valid   (frm_valid),
  .frm_len     (frm_len),
  .dst_addr    (dst_addr),
  .station_addr(station_addr),
  .chk_flag    (flt_flags[CHK_BIT]),
  .dec_done    (dec_done),
  .dec_accept  (dec_accept),
  .dec_class   (dec_class)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_valid = 1'b0;
  logic [15:0] frm_len = '0;
  logic [47:0] dst_addr = '0;
  logic [31:0] flt_flags = '0;
  logic [47:0] station_addr = '0;
  logic [47:0] mcast_addr = '0;
  logic [47:0] mcast_mask = '0;
  logic        dec_done, dec_accept;
  logic [2:0]  dec_class;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic       acc;
    logic [2:0] cls;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  rx_addr_filter dut (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_len(frm_len),
    .dst_addr(dst_addr), .flt_flags(flt_flags), .station_addr(station_addr),
    .mcast_addr(mcast_addr), .mcast_mask(mcast_mask),
    .dec_done(dec_done), .dec_accept(dec_accept), .dec_class(dec_class)
  );

  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] STA = 48'h0250_C2A1_B2C3;

  // Reference model written from the requirement list.
  function automatic exp_t model(input logic [15:0] len, input logic [47:0] d,
                                 input logic [31:0] f, input logic [47:0] st,
                                 input logic [47:0] ma, input logic [47:0] mm,
                                 input string tag);
    exp_t e;
    e.tag = tag;
    e.acc = 1'b0;
    e.cls = 3'd0;
    if (len < 16'd6)                          begin e.cls = 3'd5; end
    else if (d == BC)                         begin e.acc = 1'b1; e.cls = 3'd1; end
    else if (!f[5])                           begin e.acc = 1'b1; e.cls = 3'd2; end
    else if (ma != BC && ((d & mm) == ma))    begin e.acc = 1'b1; e.cls = 3'd3; end
    else if (d == st)                         begin e.acc = 1'b1; e.cls = 3'd4; end
    return e;
  endfunction

  // Driver: one frame per call, strobe held one cycle.
  task automatic send(input logic [15:0] len, input logic [47:0] d,
                      input logic [31:0] f, input logic [47:0] st,
                      input logic [47:0] ma, input logic [47:0] mm,
                      input string tag);
    @(negedge clk);
    frm_valid = 1'b1; frm_len = len; dst_addr = d; flt_flags = f;
    station_addr = st; mcast_addr = ma; mcast_mask = mm;
    sb.push_back(model(len, d, f, st, ma, mm, tag));
  endtask

  task automatic idle_gap();
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  // Monitor: compares each presented decision with the queue head.
  always @(negedge clk) begin
    if (!rst) begin
      if (dec_done) begin
        total++;
        if (sb.size() == 0) begin
          bad++;
          $display("FAIL R9: done with no pending frame (act done=1 exp done=0)");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (dec_accept !== e.acc || dec_class !== e.cls) begin
            bad++;
            $display("FAIL %s: act acc=%0b cls=%0d exp acc=%0b cls=%0d",
                     e.tag, dec_accept, dec_class, e.acc, e.cls);
          end
        end
      end else if (dec_accept !== 1'b0 || dec_class !== 3'd0) begin
        total++; bad++;
        $display("FAIL R10: idle outputs act acc=%0b cls=%0d exp acc=0 cls=0",
                 dec_accept, dec_class);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (dec_done !== 1'b0 || dec_accept !== 1'b0 || dec_class !== 3'd0) begin
      bad++;
      $display("FAIL R10: reset act done=%0b acc=%0b cls=%0d exp 0 0 0",
               dec_done, dec_accept, dec_class);
    end
    rst = 1'b0;

    // R8: short frames, including a short broadcast (priority over R1)
    send(16'd5,  BC,              32'h20, STA, 48'h0, 48'h0, "R8");
    send(16'd0,  STA,             32'h20, STA, BC,    BC,    "R8");
    // R8 boundary: exactly 6 bytes is evaluated, here as unicast
    send(16'd6,  STA,             32'h20, STA, BC,    BC,    "R8");
    // R1: broadcast with checking on; R7: broadcast before flag test
    send(16'd64, BC,              32'h20, STA, 48'h0100_5E00_0000, 48'hFFFF_FF80_0000, "R1");
    send(16'd64, BC,              32'h0,  STA, BC,    BC,    "R7");
    idle_gap();
    // R2: flag clear, other flag bits set, arbitrary destination
    send(16'd60, 48'h1234_5678_9ABC, 32'hFFFF_FFDF, STA, BC, BC, "R2");
    // R2: only bit 5 changes the outcome (other bits clear, bit 5 set -> reject)
    send(16'd60, 48'h1234_5678_9ABC, 32'h0000_0020, STA, BC, BC, "R2");
    // R4: masked multicast match
    send(16'd60, 48'h0100_5E12_3456, 32'h20, STA, 48'h0100_5E00_0000, 48'hFFFF_FF80_0000, "R4");
    // R4 miss: bit 23 inside mask differs
    send(16'd60, 48'h0100_5E92_3456, 32'h20, STA, 48'h0100_5E00_0000, 48'hFFFF_FF80_0000, "R4");
    // R7: multicast wins over unicast when both match
    send(16'd60, STA,             32'h20, STA, 48'h0, 48'h0, "R7");
    idle_gap();
    idle_gap();
    // R3: all-ones multicast address disables the rule, unicast decides
    send(16'd60, STA,             32'h20, STA, BC,    48'h0, "R3");
    send(16'd60, 48'h0A0B_0C0D_0E0F, 32'h20, STA, BC, BC, "R3");
    // R5: exact unicast, then single-bit differences
    send(16'd60, STA,             32'h20, STA, 48'h0100_5E00_0000, 48'hFFFF_FF80_0000, "R5");
    send(16'd60, STA ^ 48'h1,     32'h20, STA, 48'h0100_5E00_0000, 48'hFFFF_FF80_0000, "R5");
    send(16'd60, STA ^ 48'h8000_0000_0000, 32'hFFFF_FFFF, STA, BC, BC, "R5");
    // R6: nothing matches
    send(16'd1500, 48'h0011_2233_4455, 32'h20, STA, 48'h0100_5E00_0000, 48'hFFFF_FF00_0000, "R6");
    idle_gap();
    idle_gap();
    idle_gap();

    // R9: done must stay low while no strobe is given
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      total++;
      if (dec_done !== 1'b0) begin
        bad++;
        $display("FAIL R9: idle done act=%0b exp=0", dec_done);
      end
    end
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R9: missing decisions act=%0d exp=0", sb.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule